// File: doc/BRIEF.md
# Over/Under Frequency Trip with Cycle-Counted Delay

This block decides when a measured line frequency has crossed a protection threshold, and for how long. A four-digit BCD frequency word arrives with a valid strobe. On each strobe the block compares it, digit by digit, with a BCD threshold. A mode bit picks the direction. In under mode the condition is a measured value below the threshold. In over mode it is a measured value above the threshold. The result is held as an enable level until the next strobe.

While the enable level is high, each zero-cross pulse counts as one cycle of the sensed signal. A fixed number of such cycles in a row (three by default) raises the pickup indicator. After pickup, further zero-cross pulses count a definite time delay, set in sensed-signal cycles. When that count reaches the programmed delay, the trip output asserts. A strobe whose comparison fails clears all of this at once. The qualifying run must then start again from zero.

Top module: `freq_trip_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, trip_enable, pickup and trip are all low.
- R2: With over_mode low, a meas_valid strobe whose meas_bcd is numerically below setpoint_bcd sets trip_enable high on the cycle after the strobe.
- R3: With over_mode high, a meas_valid strobe whose meas_bcd is numerically above setpoint_bcd sets trip_enable high on the cycle after the strobe. A value below the threshold in this mode leaves it low.
- R4: A strobe with meas_bcd equal to setpoint_bcd drives trip_enable low in either mode.
- R5: Each 16-bit BCD word holds four decimal digits, with bits [15:12] the most significant digit and bits [3:0] the least. The first differing digit from the top decides the order, whatever the lower digits hold (5999 is below 6000).
- R6: trip_enable changes only on the cycle after a meas_valid strobe. Changes to meas_bcd, setpoint_bcd or over_mode without a strobe have no effect.
- R7: pickup rises on the cycle after the third zero-cross pulse seen while trip_enable is high, and not after the second.
- R8: Zero-cross pulses seen while trip_enable is low are not counted.
- R9: A strobe whose comparison fails drops trip_enable, pickup and trip on the next cycle. It also clears both the qualifying count and the delay count.
- R10: With delay_cycles equal to D > 0, trip rises on the cycle after the D-th zero-cross pulse that follows pickup, and stays low before it.
- R11: Once high, trip stays high while the condition holds, including across further pulses and across strobes that pass the comparison.
- R12: With delay_cycles equal to zero, trip rises in the same cycle as pickup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_bcd | input | 16 | Measured frequency, four BCD digits |
| meas_valid | input | 1 | One-cycle strobe marking meas_bcd as complete |
| setpoint_bcd | input | 16 | Threshold frequency, four BCD digits |
| over_mode | input | 1 | 1 = trip above threshold, 0 = trip below threshold |
| zc_pulse | input | 1 | One-cycle pulse per zero crossing of the sensed signal |
| delay_cycles | input | 8 | Definite delay after pickup, in sensed-signal cycles |
| trip_enable | output | 1 | Comparison condition, held between strobes |
| pickup | output | 1 | Qualifying cycle run complete |
| trip | output | 1 | Delay elapsed after pickup |

## Verification
The bench places thresholds where a lower digit disagrees with a higher one, such as 5999 against 6000. A comparator that let the low digits win would then enable in the wrong direction. It drives exact equality in both modes, which catches a comparator using "or equal". It changes the measured word without a strobe, so a design that compares continuously would toggle the enable. It counts pulses up to two and three, before and after a failing strobe, to catch an off-by-one pickup or a count that survives the clear. Delay values of zero and non-zero expose a trip that lags pickup by a cycle or fires one pulse early. A seeded random phase then runs near-threshold values against a cycle-level reference model.

// File: rtl/freq_trip_pkg.sv
package freq_trip_pkg;

    localparam int BCD_DIGIT_W = 4;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2
    } cmp_res_e;

    // per-stage control derived from the strobe and the pulse
    typedef struct packed {
        logic clear;
        logic advance;
    } stage_ctl_s;

    function automatic cmp_res_e digit_cmp(input logic [BCD_DIGIT_W-1:0] a,
                                           input logic [BCD_DIGIT_W-1:0] b);
        if (a < b) return CMP_LT;
        if (a > b) return CMP_GT;
        return CMP_EQ;
    endfunction

    function automatic logic cond_met(input cmp_res_e r, input logic over);
        return over ? (r == CMP_GT) : (r == CMP_LT);
    endfunction

endpackage

// File: rtl/bcd_mag_cmp.sv
module bcd_mag_cmp
    import freq_trip_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*BCD_DIGIT_W-1:0] lhs,
    input  logic [DIGITS*BCD_DIGIT_W-1:0] rhs,
    output cmp_res_e                      result
);
    // chain[i] holds the order decided by digits DIGITS-1 down to i
    cmp_res_e chain [0:DIGITS];

    assign chain[DIGITS] = CMP_EQ;

    for (genvar i = DIGITS - 1; i >= 0; i--) begin : g_digit
        assign chain[i] = (chain[i+1] != CMP_EQ) ? chain[i+1]
                        : digit_cmp(lhs[i*BCD_DIGIT_W +: BCD_DIGIT_W],
                                    rhs[i*BCD_DIGIT_W +: BCD_DIGIT_W]);
    end

    assign result = chain[0];
endmodule

// File: rtl/cycle_qualifier.sv
module cycle_qualifier
    import freq_trip_pkg::*;
#(
    parameter int PICKUP_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  stage_ctl_s ctl,
    output logic       pickup
);
    localparam int QW = $clog2(PICKUP_CYCLES + 1);
    localparam logic [QW-1:0] LAST = QW'(PICKUP_CYCLES - 1);

    logic [QW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            run_cnt <= '0;
            pickup  <= 1'b0;
        end else if (ctl.advance && !pickup) begin
            run_cnt <= run_cnt + 1'b1;
            if (run_cnt == LAST) pickup <= 1'b1;
        end
    end
endmodule

// File: rtl/delay_timer.sv
module delay_timer
    import freq_trip_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_ctl_s       ctl,
    input  logic [DLY_W-1:0] limit,
    output logic             elapsed
);
    logic [DLY_W-1:0] dly_cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            dly_cnt <= '0;
        end else if (ctl.advance && (dly_cnt != '1)) begin
            dly_cnt <= dly_cnt + 1'b1;
        end
    end

    assign elapsed = (dly_cnt >= limit);
endmodule

// File: rtl/freq_trip_unit.sv
module freq_trip_unit
    import freq_trip_pkg::*;
#(
    parameter int DIGITS        = 4,
    parameter int PICKUP_CYCLES = 3,
    parameter int DLY_W         = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DIGITS*BCD_DIGIT_W-1:0] meas_bcd,
    input  logic                          meas_valid,
    input  logic [DIGITS*BCD_DIGIT_W-1:0] setpoint_bcd,
    input  logic                          over_mode,
    input  logic                          zc_pulse,
    input  logic [DLY_W-1:0]              delay_cycles,
    output logic                          trip_enable,
    output logic                          pickup,
    output logic                          trip
);
    cmp_res_e   order;
    logic       cond_now;
    logic       fail_strobe;
    logic       elapsed;
    stage_ctl_s qual_ctl;
    stage_ctl_s dly_ctl;

    bcd_mag_cmp #(.DIGITS(DIGITS)) u_cmp (
        .lhs    (meas_bcd),
        .rhs    (setpoint_bcd),
        .result (order)
    );

    assign cond_now    = cond_met(order, over_mode);
    assign fail_strobe = meas_valid && !cond_now;

    // enable level is sampled only on the strobe
    always_ff @(posedge clk) begin
        if (rst)             trip_enable <= 1'b0;
        else if (meas_valid) trip_enable <= cond_now;
    end

    always_comb begin
        qual_ctl.clear   = fail_strobe;
        qual_ctl.advance = zc_pulse && trip_enable;
        dly_ctl.clear    = fail_strobe;
        dly_ctl.advance  = zc_pulse && trip_enable && pickup;
    end

    cycle_qualifier #(.PICKUP_CYCLES(PICKUP_CYCLES)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .ctl    (qual_ctl),
        .pickup (pickup)
    );

    delay_timer #(.DLY_W(DLY_W)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .ctl     (dly_ctl),
        .limit   (delay_cycles),
        .elapsed (elapsed)
    );

    assign trip = pickup && elapsed;
endmodule

// File: rtl/freq_trip_checker.sv
module freq_trip_checker #(
    parameter int W     = 16,
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     meas_bcd,
    input logic             meas_valid,
    input logic [W-1:0]     setpoint_bcd,
    input logic             zc_pulse,
    input logic [DLY_W-1:0] delay_cycles,
    input logic             trip_enable,
    input logic             pickup,
    input logic             trip
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!trip_enable && !pickup && !trip));

    assert_equal_no_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && (meas_bcd == setpoint_bcd)) |=> !trip_enable);

    assert_strobe_only_R6: assert property (@(posedge clk) disable iff (rst)
        !meas_valid |=> $stable(trip_enable));

    assert_pickup_on_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pickup) |-> $past(zc_pulse) && $past(trip_enable));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !trip_enable |-> (!pickup && !trip));

    assert_trip_needs_pickup_R10: assert property (@(posedge clk) disable iff (rst)
        trip |-> pickup);

    assert_trip_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (trip && !meas_valid) |=> (trip || !$stable(delay_cycles)));
endmodule

bind freq_trip_unit freq_trip_checker #(.W(DIGITS*4), .DLY_W(DLY_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .meas_bcd     (meas_bcd),
    .meas_valid   (meas_valid),
    .setpoint_bcd (setpoint_bcd),
    .zc_pulse     (zc_pulse),
    .delay_cycles (delay_cycles),
    .trip_enable  (trip_enable),
    .pickup       (pickup),
    .trip         (trip)
);

// File: tb/sim_freq_trip_unit.sv
`timescale 1ns/1ps
module sim_freq_trip_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] meas_bcd = '0;
    logic        meas_valid = 1'b0;
    logic [15:0] setpoint_bcd = '0;
    logic        over_mode = 1'b0;
    logic        zc_pulse = 1'b0;
    logic [7:0]  delay_cycles = '0;
    logic        trip_enable, pickup, trip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    freq_trip_unit u0 (
        .clk(clk), .rst(rst), .meas_bcd(meas_bcd), .meas_valid(meas_valid),
        .setpoint_bcd(setpoint_bcd), .over_mode(over_mode), .zc_pulse(zc_pulse),
        .delay_cycles(delay_cycles), .trip_enable(trip_enable), .pickup(pickup),
        .trip(trip)
    );

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        r[3:0]   = 4'(v % 10);
        r[7:4]   = 4'((v / 10) % 10);
        r[11:8]  = 4'((v / 100) % 10);
        r[15:12] = 4'((v / 1000) % 10);
        return r;
    endfunction

    function automatic int from_bcd(input logic [15:0] b);
        return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic bit exp_cond(input logic [15:0] m, input logic [15:0] s, input bit over);
        return over ? (from_bcd(m) > from_bcd(s)) : (from_bcd(m) < from_bcd(s));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk3(input string tag, input bit en, input bit pu, input bit tr);
        check(trip_enable == en, {tag, " enable"}, int'(trip_enable), int'(en));
        check(pickup == pu, {tag, " pickup"}, int'(pickup), int'(pu));
        check(trip == tr, {tag, " trip"}, int'(trip), int'(tr));
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic strobe(input int m, input int s, input bit over);
        meas_bcd = to_bcd(m); setpoint_bcd = to_bcd(s); over_mode = over;
        meas_valid = 1'b1; tick(); meas_valid = 1'b0;
    endtask

    task automatic zc();
        zc_pulse = 1'b1; tick(); zc_pulse = 1'b0;
    endtask

    // reference model state
    bit m_en, m_pu;
    int m_q, m_d;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        chk3("R1 in reset", 0, 0, 0);
        rst = 1'b0; tick();
        chk3("R1 after reset", 0, 0, 0);

        // comparison direction and digit priority
        strobe(5999, 6000, 0); chk3("R2 R5 under 5999<6000", 1, 0, 0);
        strobe(5000, 4999, 0); chk3("R5 under 5000>4999", 0, 0, 0);
        strobe(6001, 6000, 1); chk3("R3 over 6001>6000", 1, 0, 0);
        strobe(5999, 6000, 1); chk3("R3 over below", 0, 0, 0);
        strobe(6000, 6000, 1); chk3("R4 equal over", 0, 0, 0);
        strobe(6000, 6000, 0); chk3("R4 equal under", 0, 0, 0);

        // strobe-only evaluation
        strobe(4500, 6000, 0); chk3("R6 set", 1, 0, 0);
        meas_bcd = to_bcd(7000); over_mode = 1'b0;
        repeat (4) tick();
        chk3("R6 no strobe", 1, 0, 0);

        // pulses while disabled are ignored
        delay_cycles = 8'd2;
        strobe(6000, 6000, 0); chk3("R9 clear", 0, 0, 0);
        repeat (5) zc();
        chk3("R8 pulses while low", 0, 0, 0);
        strobe(5900, 6000, 0);
        zc(); zc(); chk3("R7 after two", 1, 0, 0);
        zc(); chk3("R7 after three", 1, 1, 0);
        zc(); chk3("R10 one of two", 1, 1, 0);
        zc(); chk3("R10 two of two", 1, 1, 1);
        zc(); zc(); chk3("R11 more pulses", 1, 1, 1);
        strobe(5800, 6000, 0); chk3("R11 passing strobe", 1, 1, 1);

        // failing strobe clears everything
        strobe(6100, 6000, 0); chk3("R9 failing strobe", 0, 0, 0);
        strobe(5900, 6000, 0);
        zc(); zc(); chk3("R9 count restarted", 1, 0, 0);

        // zero delay
        strobe(6100, 6000, 0);
        delay_cycles = 8'd0;
        strobe(6100, 6000, 1);
        zc(); zc(); chk3("R12 before pickup", 1, 0, 0);
        zc(); chk3("R12 trip with pickup", 1, 1, 1);

        // random phase against a reference model
        strobe(6000, 6000, 0);
        m_en = 0; m_pu = 0; m_q = 0; m_d = 0;
        for (int ep = 0; ep < 40; ep++) begin
            int s_int;
            bit ovr;
            s_int = 3000 + int'($urandom_range(0, 4999));
            ovr = bit'($urandom_range(0, 1));
            delay_cycles = 8'($urandom_range(0, 4));
            setpoint_bcd = to_bcd(s_int);
            over_mode = ovr;
            for (int c = 0; c < 80; c++) begin
                bit v, z, cnd;
                int m_int;
                v = ($urandom_range(0, 5) == 0);
                z = ($urandom_range(0, 3) == 0);
                m_int = s_int + int'($urandom_range(0, 12)) - 4;
                if (!ovr) m_int = s_int - int'($urandom_range(0, 12)) + 4;
                meas_bcd = to_bcd(m_int);
                meas_valid = v; zc_pulse = z;
                cnd = exp_cond(meas_bcd, setpoint_bcd, ovr);
                if (v && !cnd) begin
                    m_q = 0; m_pu = 0; m_d = 0;
                end else if (z && m_en) begin
                    if (!m_pu) begin
                        m_q++;
                        if (m_q == 3) m_pu = 1;
                    end else if (m_d < 255) begin
                        m_d++;
                    end
                end
                if (v) m_en = cnd;
                tick();
                chk3("R11 random model", m_en, m_pu, m_pu && (m_d >= int'(delay_cycles)));
            end
            meas_valid = 0; zc_pulse = 0;
            strobe(s_int, s_int, ovr);
            m_en = 0; m_pu = 0; m_q = 0; m_d = 0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule